// File: doc/BRIEF.md
# Ganged Output Port Controller

This block drives an eight-pin general-purpose output port from a small bank of registers on a synchronous register bus. Each pin has its own output value, direction, drive-strength and slew-rate bit. Software writes these registers, and the block turns them into per-pin pad controls: the value to drive, an output enable, a high-drive select and a fast-slew select.

A separate gang register lets several pins act as one wider driver led by pin 0. One bit of this register is a global enable. The other bits each pick a follower pin. While the enable is set, pin 0 always drives. Every selected follower copies pin 0's value, drive strength and slew, and is forced to drive as well. The gang register accepts exactly one write after reset. Any later write to it is dropped, so the gang setup cannot be changed by accident once it has been made.

The register bus is a plain control interface. A write takes effect at the clock edge where `bus_we` is high. The read data is combinational from `bus_addr`. The bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `gang_gpio_port`

## Requirements
- R1: After a synchronous reset, every register reads 0 and all four per-pin output vectors are 0.
- R2: The value register is at address 0, direction at 1, drive strength at 2 and slew at 3. Each can be written any number of times, and a read at its address returns the last value written.
- R3: The gang register is at address 4. Bit 0 is the enable and bit n (n = 1..7) selects pin n. The first write after reset is stored, every later write is ignored, and reads return the stored value.
- R4: While the gang enable is 1, `pin_oe[0]` is 1 whatever direction bit 0 holds.
- R5: While the gang enable is 1, each selected pin drives the value bit of pin 0 on `pin_out`.
- R6: While the gang enable is 1, each selected pin takes its drive-strength and slew selection from pin 0's register bits.
- R7: While the gang enable is 1, each selected pin has `pin_oe` = 1.
- R8: While the gang enable is 0, select bits are stored but have no effect, and every pin uses its own settings. This holds even when the select bits were written in the same write that left the enable at 0.
- R9: `pin_hidrive[n]` and `pin_fastslew[n]` are 0 whenever `pin_oe[n]` is 0, so the drive and slew bits have no effect on an input pin.
- R10: Addresses 5 to 7 read as 0, and writes to them change no register or output.
- R11: A pin that is not ganged has `pin_out` equal to its value bit and `pin_oe` equal to its direction bit, where 1 means output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Output enable for each pin |
| pin_hidrive | output | 8 | High drive strength select for each pin |
| pin_fastslew | output | 8 | Fast slew select for each pin |

## Verification
The pin outputs are combinational from the registers, so any wrong register content shows up at the pin ports in the cycle after the write that caused it. A write-once lock that fails to engage shows up as a changed gang readback, and as moved followers, right after the second write to address 4. A lock that engages too early shows up as a gang register that stays 0 after its first write. A wrong mux select on a follower shows up at once as that pin's value, enable or drive disagreeing with pin 0.

// File: rtl/gang_gpio_pkg.sv
package gang_gpio_pkg;
  localparam int ADDR_W  = 3;
  localparam int N_PLAIN = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA  = 3'd0,
    RA_DIR   = 3'd1,
    RA_DRIVE = 3'd2,
    RA_SLEW  = 3'd3,
    RA_GANG  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gang_plain_regs.sv
module gang_plain_regs
  import gang_gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [PINS-1:0]                 wdata,
  output logic [N_PLAIN-1:0][PINS-1:0]    q
);
  // One freely rewritable register per plain address (value, direction, drive, slew)
  for (genvar k = 0; k < N_PLAIN; k++) begin : g_reg
    logic [PINS-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r <= '0;
      end else if (we && addr == ADDR_W'(k)) begin
        r <= wdata;
      end
    end
    assign q[k] = r;
  end
endmodule

// File: rtl/gang_lock_reg.sv
module gang_lock_reg
  import gang_gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   gang_q
);
  logic locked;

  // First accepted write stores the value and sets the lock; only reset clears it
  always_ff @(posedge clk) begin
    if (rst) begin
      gang_q <= '0;
      locked <= 1'b0;
    end else if (we && addr == RA_GANG && !locked) begin
      gang_q <= wdata;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/gang_pin_mux.sv
module gang_pin_mux #(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] dat,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] drv,
  input  logic [PINS-1:0] slw,
  input  logic [PINS-1:0] gang,
  output logic [PINS-1:0] out_o,
  output logic [PINS-1:0] oe_o,
  output logic [PINS-1:0] hid_o,
  output logic [PINS-1:0] fast_o
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    if (n == 0) begin : g_lead
      // Leader pin: always drives while ganging is on
      assign out_o[0]  = dat[0];
      assign oe_o[0]   = dir[0] | gang[0];
      assign hid_o[0]  = oe_o[0] & drv[0];
      assign fast_o[0] = oe_o[0] & slw[0];
    end else begin : g_follow
      // Follower pin: slaved to the leader only when enable and select are both set
      logic joined;
      assign joined    = gang[0] & gang[n];
      assign out_o[n]  = joined ? dat[0] : dat[n];
      assign oe_o[n]   = joined | dir[n];
      assign hid_o[n]  = oe_o[n] & (joined ? drv[0] : drv[n]);
      assign fast_o[n] = oe_o[n] & (joined ? slw[0] : slw[n]);
    end
  end
endmodule

// File: rtl/gang_gpio_port.sv
module gang_gpio_port
  import gang_gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_hidrive,
  output logic [PINS-1:0]   pin_fastslew
);
  logic [N_PLAIN-1:0][PINS-1:0] plain_q;
  logic [PINS-1:0] dat_q, dir_q, drv_q, slw_q, gang_q;

  gang_plain_regs #(.PINS(PINS)) u_plain (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(plain_q)
  );

  gang_lock_reg #(.PINS(PINS)) u_lock (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .gang_q(gang_q)
  );

  assign dat_q = plain_q[RA_DATA];
  assign dir_q = plain_q[RA_DIR];
  assign drv_q = plain_q[RA_DRIVE];
  assign slw_q = plain_q[RA_SLEW];

  gang_pin_mux #(.PINS(PINS)) u_mux (
    .dat(dat_q), .dir(dir_q), .drv(drv_q), .slw(slw_q), .gang(gang_q),
    .out_o(pin_out), .oe_o(pin_oe), .hid_o(pin_hidrive), .fast_o(pin_fastslew)
  );

  always_comb begin
    case (bus_addr)
      RA_DATA:  bus_rdata = dat_q;
      RA_DIR:   bus_rdata = dir_q;
      RA_DRIVE: bus_rdata = drv_q;
      RA_SLEW:  bus_rdata = slw_q;
      RA_GANG:  bus_rdata = gang_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gang_gpio_chk.sv
module gang_gpio_chk
  import gang_gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   gang_q,
  input logic [PINS-1:0]   dat_q,
  input logic [PINS-1:0]   dir_q,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   pin_hidrive,
  input logic [PINS-1:0]   pin_fastslew
);
  logic seen_wr;
  logic [PINS-1:0] mask;

  assign mask = {gang_q[PINS-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) seen_wr <= 1'b0;
    else if (bus_we && bus_addr == RA_GANG) seen_wr <= 1'b1;
  end

  p_gang_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (seen_wr && bus_we && bus_addr == RA_GANG) |=> $stable(gang_q));

  p_lead_drives_r4: assert property (@(posedge clk) disable iff (rst)
    gang_q[0] |-> pin_oe[0]);

  p_follow_value_r5: assert property (@(posedge clk) disable iff (rst)
    gang_q[0] |-> ((pin_out & mask) == (mask & {PINS{pin_out[0]}})));

  p_follow_drive_r6: assert property (@(posedge clk) disable iff (rst)
    gang_q[0] |-> (((pin_hidrive & mask) == (mask & {PINS{pin_hidrive[0]}})) &&
                   ((pin_fastslew & mask) == (mask & {PINS{pin_fastslew[0]}}))));

  p_follow_oe_r7: assert property (@(posedge clk) disable iff (rst)
    gang_q[0] |-> ((pin_oe & mask) == mask));

  p_gang_off_r8: assert property (@(posedge clk) disable iff (rst)
    !gang_q[0] |-> (pin_oe == dir_q && pin_out == dat_q));

  p_input_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((pin_hidrive | pin_fastslew) & ~pin_oe) == '0);
endmodule

bind gang_gpio_port gang_gpio_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .gang_q(gang_q), .dat_q(dat_q), .dir_q(dir_q),
  .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_hidrive(pin_hidrive), .pin_fastslew(pin_fastslew)
);

// File: tb/sim_gang_gpio_port.sv
`timescale 1ns/1ps
module sim_gang_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_hidrive, pin_fastslew;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gang_gpio_port u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_hidrive(pin_hidrive), .pin_fastslew(pin_fastslew)
  );

  // {addr, wdata, readback, out, oe, hidrive, fastslew} after each write, one scenario
  localparam int NV = 12;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 8'hA5, 8'hA5, 8'hA5, 8'h00, 8'h00, 8'h00},
    {3'd1, 8'h0F, 8'h0F, 8'hA5, 8'h0F, 8'h00, 8'h00},
    {3'd2, 8'hFF, 8'hFF, 8'hA5, 8'h0F, 8'h0F, 8'h00},
    {3'd3, 8'h3C, 8'h3C, 8'hA5, 8'h0F, 8'h0F, 8'h0C},
    {3'd0, 8'h5A, 8'h5A, 8'h5A, 8'h0F, 8'h0F, 8'h0C},
    {3'd1, 8'hF0, 8'hF0, 8'h5A, 8'hF0, 8'hF0, 8'h30},
    {3'd4, 8'h31, 8'h31, 8'h4A, 8'hF1, 8'hF1, 8'h00},
    {3'd4, 8'hFF, 8'h31, 8'h4A, 8'hF1, 8'hF1, 8'h00},
    {3'd0, 8'h5B, 8'h5B, 8'h7B, 8'hF1, 8'hF1, 8'h00},
    {3'd3, 8'h01, 8'h01, 8'h7B, 8'hF1, 8'hF1, 8'h31},
    {3'd2, 8'h00, 8'h00, 8'h7B, 8'hF1, 8'h00, 8'h31},
    {3'd1, 8'h00, 8'h00, 8'h7B, 8'h31, 8'h00, 8'h31}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 4: return "R2 R11";
      2, 3, 5: return "R9 R2";
      6:       return "R4 R5 R6 R7";
      7:       return "R3 lock";
      8:       return "R5 follow value";
      9, 10:   return "R6 follow drive/slew";
      default: return "R7 R4 forced enable";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Write at a falling edge, sample after the next rising edge at the following falling edge
  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic check_pins(string req, logic [7:0] o, logic [7:0] e, logic [7:0] h, logic [7:0] s);
    chk(req, "pin_out", pin_out, o);
    chk(req, "pin_oe", pin_oe, e);
    chk(req, "pin_hidrive", pin_hidrive, h);
    chk(req, "pin_fastslew", pin_fastslew, s);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][50:48], VEC[i][47:40]);
      chk(vec_tag(i), "readback", bus_rdata, VEC[i][39:32]);
      check_pins(vec_tag(i), VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R1: reset clears all registers and outputs, including the gang lock
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_pins("R1", 8'h00, 8'h00, 8'h00, 8'h00);
    for (int a = 0; a < 5; a++) begin
      bus_addr = 3'(a);
      #0.5;
      chk("R1", "reset readback", bus_rdata, 8'h00);
    end

    // R10: unmapped address reads 0 and a write there changes nothing
    wr(3'd5, 8'hFF);
    chk("R10", "unmapped read", bus_rdata, 8'h00);
    check_pins("R10", 8'h00, 8'h00, 8'h00, 8'h00);
    bus_addr = 3'd0; #0.5;
    chk("R10", "value reg untouched", bus_rdata, 8'h00);

    // R8: select stored with enable 0 has no effect
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h02);
    chk("R8", "gang readback", bus_rdata, 8'h02);
    check_pins("R8", 8'h01, 8'h00, 8'h00, 8'h00);

    // R3: lock set by the first write even though the enable was 0
    wr(3'd4, 8'h03);
    chk("R3", "gang readback after 2nd write", bus_rdata, 8'h02);
    check_pins("R3", 8'h01, 8'h00, 8'h00, 8'h00);

    // R11 / R8: pin 1 follows its own settings
    wr(3'd1, 8'h02);
    check_pins("R11", 8'h01, 8'h02, 8'h00, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule